// File: doc/BRIEF.md
# Bus Breakpoint and Single-Step Controller

This block sits beside a 24-bit system bus and stalls the current bus master when a bus cycle presents an address that equals a value set on static switches. The master is held by deasserting a ready line. While it is held, an operator can release exactly one more bus cycle per press of a step button, or press a run button to return to free running. A level halt switch stops the master at the next bus cycle, whatever its address.

On every bus cycle the block registers the address, the status and control strobes, and the data word. The display therefore shows stable values even when the master runs far faster than a person can read. The data word is either 8 or 16 bits wide, chosen by an input. Everything is built from clocked registers. There are no delay elements or pulse stretchers, so the block behaves the same at any bus clock rate.

Top module: `bus_brkpt_ctl`

## Requirements
- R1: After reset the block is free running: `bus_rdy`=1, `halted`=0, and `disp_addr`, `disp_data` and `disp_stat` are all zero.
- R2: While running, if `addr_stb` is high on a clock edge with `bp_en`=1, the compare armed, and `bus_addr` equal to `bp_addr`, then from the next cycle `halted`=1 and `bus_rdy`=0.
- R3: With `bp_en`=0 and the halt switch off, no address stops the master.
- R4: An address equal to `bp_addr` on the bus without `addr_stb` never halts.
- R5: While running or stepping, `disp_addr` and `disp_stat` load on each `addr_stb`. This includes the strobe that halts. While halted, they hold their values and `addr_stb` is ignored.
- R6: `disp_data` loads on each `data_stb`. With `wide_sel`=1 all 16 bits are kept. With `wide_sel`=0, bits 15:8 read zero.
- R7: A step press is synchronized and edge-detected. The press makes `bus_rdy` high three clocks after it first appears. The next `addr_stb` captures that cycle and halts again. Holding the button gives only one step.
- R8: A run press (edge, synchronized) leaves halt and disarms the compare. The first strobe after resume cannot halt on a match. A strobe at any other address re-arms the compare.
- R9: While the synchronized halt switch is on, the next `addr_stb` halts the master regardless of address or `bp_en`.
- R10: If a run press lands on the same clock as an `addr_stb` while halted, the run takes effect. That strobe neither loads the display nor re-arms the compare.
- R11: If run and step are pressed together while halted, the run wins and the block free runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_stat | input | 8 | Status and control strobes of the bus |
| addr_stb | input | 1 | One-clock pulse: address and status valid |
| data_stb | input | 1 | One-clock pulse: data valid |
| bp_addr | input | 24 | Breakpoint address switches |
| bp_en | input | 1 | Breakpoint enable switch |
| halt_sw | input | 1 | Halt switch (asynchronous level) |
| wide_sel | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| step_btn | input | 1 | Single-step button (asynchronous) |
| run_btn | input | 1 | Run button (asynchronous) |
| bus_rdy | output | 1 | Ready to master; low stalls the cycle |
| halted | output | 1 | Master is held |
| disp_addr | output | 24 | Registered address |
| disp_data | output | 16 | Registered data |
| disp_stat | output | 8 | Registered status |

## Verification
The risky coincidence is a run press whose synchronized edge falls on the same clock as an address strobe while the master is halted. The bench times the button so its edge-detect pulse lines up with a strobe at an address that differs from the breakpoint. It then checks three things: `halted` drops, `disp_addr` keeps its halted value, and a following strobe at the breakpoint address does not halt. That last point proves the run's disarm beat the re-arm the strobe would otherwise have made. A run press and a step press on the same clock are judged the same way: an off-match cycle after the presses must leave the block running.

// File: rtl/bbk_pkg.sv
package bbk_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_STEP = 2'd2
   } bbk_state_t;
endpackage

// File: rtl/bbk_sync_edge.sv
module bbk_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], raw};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/bbk_addr_cmp.sv
module bbk_addr_cmp #(
   parameter int ADDR_W  = 24,
   parameter int SLICE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic              addr_stb,
   input  logic              disarm,
   output logic              hit,
   output logic              armed
);
   localparam int NSLICE = (ADDR_W + SLICE_W - 1) / SLICE_W;
   localparam int PAD_W  = NSLICE * SLICE_W;

   logic [PAD_W-1:0]  a_pad, b_pad;
   logic [NSLICE-1:0] slice_eq;

   assign a_pad = PAD_W'(bus_addr);
   assign b_pad = PAD_W'(bp_addr);

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      assign slice_eq[s] = (a_pad[s*SLICE_W +: SLICE_W] == b_pad[s*SLICE_W +: SLICE_W]);
   end

   assign hit = &slice_eq;

   // disarm from a run press outranks the re-arm of a strobe in the same clock
   always_ff @(posedge clk) begin
      if (!rst_n)        armed <= 1'b1;
      else if (disarm)   armed <= 1'b0;
      else if (addr_stb) armed <= ~hit;
   end
endmodule

// File: rtl/bbk_step_fsm.sv
module bbk_step_fsm
   import bbk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       addr_stb,
   input  logic       bp_en,
   input  logic       armed,
   input  logic       hit,
   input  logic       halt_lvl,
   input  logic       run_p,
   input  logic       step_p,
   output bbk_state_t state
);
   logic stop_now;
   assign stop_now = addr_stb & (halt_lvl | (bp_en & armed & hit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_RUN;
      end else begin
         unique case (state)
            ST_RUN:  if (!run_p && stop_now) state <= ST_HALT;
            ST_HALT: if (run_p)              state <= ST_RUN;
                     else if (step_p)        state <= ST_STEP;
            ST_STEP: if (run_p)              state <= ST_RUN;
                     else if (addr_stb)      state <= ST_HALT;
            default:                         state <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/bbk_capture.sv
module bbk_capture #(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int STAT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic              data_load,
   input  logic              wide_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [STAT_W-1:0] bus_stat,
   output logic [ADDR_W-1:0] disp_addr,
   output logic [DATA_W-1:0] disp_data,
   output logic [STAT_W-1:0] disp_stat
);
   logic [DATA_W-1:0] data_in;

   if (DATA_W > NARROW_W) begin : g_two_widths
      localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
      assign data_in = wide_sel ? bus_data : (bus_data & LOW_MASK);
   end else begin : g_one_width
      logic unused_sel;
      assign unused_sel = wide_sel;
      assign data_in    = bus_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_addr <= '0;
         disp_stat <= '0;
      end else if (addr_load) begin
         disp_addr <= bus_addr;
         disp_stat <= bus_stat;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         disp_data <= '0;
      else if (data_load) disp_data <= data_in;
   end
endmodule

// File: rtl/bus_brkpt_ctl.sv
module bus_brkpt_ctl
   import bbk_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 16,
   parameter int NARROW_W    = 8,
   parameter int STAT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CMP_SLICE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [STAT_W-1:0] bus_stat,
   input  logic              addr_stb,
   input  logic              data_stb,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic              bp_en,
   input  logic              halt_sw,
   input  logic              wide_sel,
   input  logic              step_btn,
   input  logic              run_btn,
   output logic              bus_rdy,
   output logic              halted,
   output logic [ADDR_W-1:0] disp_addr,
   output logic [DATA_W-1:0] disp_data,
   output logic [STAT_W-1:0] disp_stat
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bus_brkpt_ctl: SYNC_STAGES must be at least 2");
   end
   if (NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_width
      $error("bus_brkpt_ctl: NARROW_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 1 || CMP_SLICE_W < 1) begin : g_bad_addr
      $error("bus_brkpt_ctl: ADDR_W and CMP_SLICE_W must be positive");
   end

   logic       step_p, run_p, halt_lvl;
   logic       step_lvl_unused, run_lvl_unused, halt_rise_unused;
   logic       addr_hit, armed;
   bbk_state_t state;

   bbk_sync_edge #(.STAGES(SYNC_STAGES)) u_step_sync (
      .clk(clk), .rst_n(rst_n), .raw(step_btn), .level(step_lvl_unused), .rise(step_p));
   bbk_sync_edge #(.STAGES(SYNC_STAGES)) u_run_sync (
      .clk(clk), .rst_n(rst_n), .raw(run_btn), .level(run_lvl_unused), .rise(run_p));
   bbk_sync_edge #(.STAGES(SYNC_STAGES)) u_halt_sync (
      .clk(clk), .rst_n(rst_n), .raw(halt_sw), .level(halt_lvl), .rise(halt_rise_unused));

   bbk_addr_cmp #(.ADDR_W(ADDR_W), .SLICE_W(CMP_SLICE_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bp_addr(bp_addr),
      .addr_stb(addr_stb), .disarm(run_p), .hit(addr_hit), .armed(armed));

   bbk_step_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .bp_en(bp_en), .armed(armed),
      .hit(addr_hit), .halt_lvl(halt_lvl), .run_p(run_p), .step_p(step_p), .state(state));

   bbk_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W), .STAT_W(STAT_W)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .addr_load(addr_stb && (state != ST_HALT)),
      .data_load(data_stb), .wide_sel(wide_sel),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_stat(bus_stat),
      .disp_addr(disp_addr), .disp_data(disp_data), .disp_stat(disp_stat));

   assign halted  = (state == ST_HALT);
   assign bus_rdy = (state != ST_HALT);
endmodule

// File: rtl/bus_brkpt_ctl_chk.sv
module bus_brkpt_ctl_chk
   import bbk_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_stb,
   input logic              data_stb,
   input logic              bp_en,
   input logic              wide_sel,
   input logic              addr_hit,
   input logic              armed,
   input logic              halt_lvl,
   input logic              run_p,
   input bbk_state_t        state,
   input logic              halted,
   input logic [ADDR_W-1:0] disp_addr,
   input logic [DATA_W-1:0] disp_data
);
   // R2
   halt_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && addr_stb && bp_en && armed && addr_hit && !run_p) |=> halted);
   // R3
   no_halt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !bp_en && !halt_lvl) |=> !halted);
   // R5
   hold_display_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(disp_addr));
   // R6
   narrow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_stb && !wide_sel) |=> ((disp_data >> NARROW_W) == '0));
   // R7
   step_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEP && addr_stb && !run_p) |=> halted);
   // R8
   run_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_p |=> (!halted && !armed));
endmodule

bind bus_brkpt_ctl bus_brkpt_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .data_stb(data_stb), .bp_en(bp_en),
   .wide_sel(wide_sel), .addr_hit(addr_hit), .armed(armed), .halt_lvl(halt_lvl),
   .run_p(run_p), .state(state), .halted(halted), .disp_addr(disp_addr), .disp_data(disp_data));

// File: tb/bus_brkpt_ctl_test.sv
module bus_brkpt_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [15:0] bus_data = '0;
   logic [7:0]  bus_stat = '0;
   logic        addr_stb = 1'b0, data_stb = 1'b0;
   logic [23:0] bp_addr = 24'h001234;
   logic        bp_en = 1'b1, halt_sw = 1'b0, wide_sel = 1'b1;
   logic        step_btn = 1'b0, run_btn = 1'b0;
   logic        bus_rdy, halted;
   logic [23:0] disp_addr;
   logic [15:0] disp_data;
   logic [7:0]  disp_stat;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bus_brkpt_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data), .bus_stat(bus_stat),
      .addr_stb(addr_stb), .data_stb(data_stb), .bp_addr(bp_addr), .bp_en(bp_en),
      .halt_sw(halt_sw), .wide_sel(wide_sel), .step_btn(step_btn), .run_btn(run_btn),
      .bus_rdy(bus_rdy), .halted(halted), .disp_addr(disp_addr), .disp_data(disp_data),
      .disp_stat(disp_stat));

   // vector: {bp_en, wide, addr[23:0], data[15:0], expect_halt}
   localparam int NV = 9;
   localparam logic [42:0] VEC [NV] = '{
      {1'b1, 1'b1, 24'h000100, 16'hA55A, 1'b0},
      {1'b1, 1'b0, 24'h001234, 16'hBEEF, 1'b1},
      {1'b1, 1'b1, 24'h001234, 16'h1357, 1'b0},
      {1'b1, 1'b0, 24'h001235, 16'h2468, 1'b0},
      {1'b0, 1'b1, 24'h001234, 16'hC0DE, 1'b0},
      {1'b1, 1'b1, 24'hFF1234, 16'h0F0F, 1'b0},
      {1'b1, 1'b0, 24'h001234, 16'hF00D, 1'b1},
      {1'b1, 1'b1, 24'h801234, 16'h7E57, 1'b0},
      {1'b1, 1'b1, 24'h001234, 16'h4321, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic [23:0] a, input logic [15:0] d, input logic [7:0] s);
      @(negedge clk);
      bus_addr = a; bus_stat = s; addr_stb = 1'b1;
      @(negedge clk);
      addr_stb = 1'b0; bus_data = d; data_stb = 1'b1;
      @(negedge clk);
      data_stb = 1'b0;
   endtask

   task automatic press_run();
      @(negedge clk); run_btn = 1'b1;
      repeat (4) @(negedge clk);
      run_btn = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [23:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdy", 32'(bus_rdy), 1);
      chk("R1 halted", 32'(halted), 0);
      chk("R1 addr", 32'(disp_addr), 0);
      chk("R1 data", 32'(disp_data), 0);
      chk("R1 stat", 32'(disp_stat), 0);

      // R4 breakpoint address present without a strobe
      @(negedge clk); bus_addr = 24'h001234;
      repeat (4) @(negedge clk);
      chk("R4 no strobe no halt", 32'(halted), 0);
      bus_cycle(24'h000040, 16'h0, 8'h00);

      // table: R2 R3 R5 R6 R8
      for (int i = 0; i < NV; i++) begin
         logic [15:0] dexp;
         bp_en    = VEC[i][42];
         wide_sel = VEC[i][41];
         bus_cycle(VEC[i][40:17], VEC[i][16:1], 8'(i + 8'h30));
         dexp = VEC[i][41] ? VEC[i][16:1] : {8'h00, VEC[i][8:1]};
         chk("R2/R3/R8 halt", 32'(halted), 32'(VEC[i][0]));
         chk("R2 rdy", 32'(bus_rdy), 32'(!VEC[i][0]));
         chk("R5 addr", 32'(disp_addr), 32'(VEC[i][40:17]));
         chk("R5 stat", 32'(disp_stat), 32'(i + 8'h30));
         chk("R6 data", 32'(disp_data), 32'(dexp));
         if (VEC[i][0]) press_run();
      end
      bp_en = 1'b1; wide_sel = 1'b1;

      // halt at breakpoint again (re-arm first)
      bus_cycle(24'h000050, 16'h0, 8'h00);
      bus_cycle(24'h001234, 16'h1111, 8'h0A);
      chk("R2 halt", 32'(halted), 1);
      // R5 strobe while halted is ignored
      bus_cycle(24'h00ABCD, 16'h2222, 8'h0B);
      chk("R5 held addr", 32'(disp_addr), 32'(24'h001234));
      chk("R5 held stat", 32'(disp_stat), 32'h0A);

      // R7 single step, button held
      @(negedge clk); step_btn = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7 still held at 2", 32'(bus_rdy), 0);
      @(negedge clk);
      chk("R7 rdy after 3", 32'(bus_rdy), 1);
      repeat (6) @(negedge clk);
      chk("R7 stepping waits", 32'(halted), 0);
      bus_cycle(24'h000500, 16'h3333, 8'h0C);
      chk("R7 halts after step", 32'(halted), 1);
      chk("R7 captured", 32'(disp_addr), 32'(24'h000500));
      repeat (6) @(negedge clk);
      chk("R7 one step per press", 32'(halted), 1);
      step_btn = 1'b0;
      repeat (3) @(negedge clk);

      // R10 run pulse coincident with strobe while halted
      press_run();
      bus_cycle(24'h000060, 16'h0, 8'h00);
      bus_cycle(24'h001234, 16'h0, 8'h0D);
      chk("R10 setup halt", 32'(halted), 1);
      held = disp_addr;
      @(negedge clk); run_btn = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_addr = 24'h000999; addr_stb = 1'b1;
      @(negedge clk); addr_stb = 1'b0;
      chk("R10 run wins", 32'(halted), 0);
      chk("R10 no capture", 32'(disp_addr), 32'(held));
      repeat (3) @(negedge clk); run_btn = 1'b0;
      repeat (3) @(negedge clk);
      bus_cycle(24'h001234, 16'h0, 8'h00);
      chk("R10 still disarmed", 32'(halted), 0);
      bus_cycle(24'h000010, 16'h0, 8'h00);
      bus_cycle(24'h001234, 16'h0, 8'h00);
      chk("R8 re-armed", 32'(halted), 1);

      // R11 run and step together
      @(negedge clk); run_btn = 1'b1; step_btn = 1'b1;
      repeat (4) @(negedge clk);
      run_btn = 1'b0; step_btn = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 running", 32'(bus_rdy), 1);
      bus_cycle(24'h000070, 16'h0, 8'h00);
      chk("R11 no halt after cycle", 32'(halted), 0);

      // R9 halt switch
      bp_en = 1'b0;
      @(negedge clk); halt_sw = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 no halt before strobe", 32'(halted), 0);
      bus_cycle(24'h000777, 16'h0, 8'h00);
      chk("R9 halt switch", 32'(halted), 1);
      chk("R9 addr", 32'(disp_addr), 32'(24'h000777));
      halt_sw = 1'b0;
      repeat (3) @(negedge clk);
      press_run();
      bus_cycle(24'h000778, 16'h0, 8'h00);
      chk("R3 free run", 32'(halted), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule